// File: doc/BRIEF.md
# Ethernet UDP test-frame generator

This block produces bursts of Ethernet test frames on an 8-bit streaming master with a valid/ready handshake and an end-of-frame marker. Each frame is either a raw MAC frame (a 14-byte Ethernet header whose last two bytes carry the payload length) or a UDP datagram (Ethernet, IPv4 and UDP headers, 42 bytes in all). The header is followed by a payload whose bytes depend only on their position in the frame. Preamble, FCS and padding are left to the MAC that consumes the stream.

Software programs the addresses, ports, payload lengths, frame count and inter-frame gap through a zero-wait register slave with an APB-style select/enable strobe. It chooses the mode in a select register and then raises the matching start bit. The block streams the programmed number of frames. After each accepted final byte it idles for the programmed number of clocks, and then it returns to idle. Payload length, count, gap and mode are captured when the burst launches.

Top module: `eth_test_gen`

## Requirements
- R1: After reset, m_tvalid and m_tlast are low, the busy flag (CTRL bit 8) reads 0 and every register reads 0.
- R2: A write takes effect on a clock edge with psel, penable and pwrite all high. Every register reads back the value written to it in its fields: word 0 CTRL bits 1:0, word 1 SEL bit 0, word 2 BURST (gap in bits 31:16, count in bits 15:0), words 3/4 destination MAC low 32/high 16, words 5/6 source MAC low/high, word 7 source IPv4, word 8 destination IPv4, word 9 ports (destination in 31:16, source in 15:0), word 10 raw payload length, word 11 UDP payload length. CTRL bit 8 is read-only and reads 1 while a burst runs.
- R3: A burst launches when a CTRL write takes a start bit from 0 to 1 and that bit matches SEL. Bit 1 starts a raw burst and is honoured only when SEL bit 0 = 1. Bit 0 starts a UDP burst and is honoured only when SEL bit 0 = 0. A mismatched start produces no output.
- R4: A UDP frame is 42 + N bytes, N being the UDP payload length. It carries destination MAC, source MAC (most significant byte first), EtherType 0x08 0x00, then 0x45, 0x00, total length N+28, identification 0, flags/fragment 0, TTL 64, protocol 17, checksum, source IP, destination IP, source port, destination port, UDP length N+8 and UDP checksum 0. All multi-byte fields are big-endian.
- R5: IPv4 header bytes 24–25 hold the one's complement of the folded one's-complement sum of the ten 16-bit header words, with the checksum field taken as zero.
- R6: A raw frame is 14 + N bytes, N being the raw payload length. It carries destination MAC, source MAC, then N as two big-endian bytes.
- R7: Counting from the first destination-MAC byte as index 0, each payload byte at index k equals (k − 42) mod 256. Raw payload starts at k = 14 and UDP payload starts at k = 42.
- R8: m_tlast is high only on the final byte of each frame. A burst delivers exactly the programmed count of frames and then busy drops.
- R9: Between frames of a burst, m_tvalid stays low for exactly the programmed gap in clocks, counted from the clock after the final byte is accepted. A gap of 0 gives back-to-back frames.
- R10: While m_tvalid is high and m_tready is low, m_tdata, m_tlast and m_tvalid hold their values.
- R11: A start edge that arrives while a burst runs is ignored, and a start with a programmed count of 0 launches nothing.
- R12: A payload length of 0 yields a header-only frame (42 bytes UDP, 14 bytes raw) whose final header byte carries m_tlast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register slave select |
| penable | input | 1 | Register access enable phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Register word address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr (combinational) |
| m_tdata | output | 8 | Stream byte |
| m_tvalid | output | 1 | Stream byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Final byte of frame |

## Verification
A wrong byte index or header mux shows up at once as a mismatched byte at that frame position. A wrong checksum sum shows up at bytes 24–25 of every UDP frame. A bad frame or gap counter shows up at the first frame boundary, as a misplaced m_tlast, too many or too few idle clocks, or surplus and missing frames. The scoreboard flags these against its queue of expected bytes within a cycle. A start decoder that ignores SEL or the busy state shows up within a few cycles, as output that should not exist, or as a second frame queued behind the first.

// File: rtl/tg_pkg.sv
package tg_pkg;

  localparam int REG_AW   = 4;
  localparam int FLD_W    = 16;
  localparam int IDX_W    = FLD_W + 1;
  localparam int UDP_HDR  = 42;
  localparam int RAW_HDR  = 14;
  localparam logic [7:0] IP_TTL   = 8'd64;
  localparam logic [7:0] IP_PROTO = 8'd17;

  localparam logic [REG_AW-1:0] A_CTRL    = 4'd0;
  localparam logic [REG_AW-1:0] A_SEL     = 4'd1;
  localparam logic [REG_AW-1:0] A_BURST   = 4'd2;
  localparam logic [REG_AW-1:0] A_DMAC_LO = 4'd3;
  localparam logic [REG_AW-1:0] A_DMAC_HI = 4'd4;
  localparam logic [REG_AW-1:0] A_SMAC_LO = 4'd5;
  localparam logic [REG_AW-1:0] A_SMAC_HI = 4'd6;
  localparam logic [REG_AW-1:0] A_SIP     = 4'd7;
  localparam logic [REG_AW-1:0] A_DIP     = 4'd8;
  localparam logic [REG_AW-1:0] A_PORTS   = 4'd9;
  localparam logic [REG_AW-1:0] A_RAWLEN  = 4'd10;
  localparam logic [REG_AW-1:0] A_UDPLEN  = 4'd11;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} seq_st_t;

  // header size in bytes for the selected mode
  function automatic logic [IDX_W-1:0] hdr_len(input logic raw);
    return raw ? IDX_W'(RAW_HDR) : IDX_W'(UDP_HDR);
  endfunction

  // byte i (0 = most significant) of a 48-bit address
  function automatic logic [7:0] mac_byte(input logic [47:0] mac, input logic [2:0] i);
    logic [5:0]  sh;
    logic [47:0] t;
    sh = {3'(3'd5 - i), 3'b000};
    t  = mac >> sh;
    return t[7:0];
  endfunction

  // IPv4 header checksum over the fixed-format header
  function automatic logic [15:0] ip_csum(input logic [15:0] tot_len,
                                          input logic [31:0] sip,
                                          input logic [31:0] dip);
    logic [19:0] s;
    s = 20'h04500 + 20'(tot_len) + 20'({IP_TTL, IP_PROTO})
      + 20'(sip[31:16]) + 20'(sip[15:0]) + 20'(dip[31:16]) + 20'(dip[15:0]);
    s = 20'(s[15:0]) + 20'(s[19:16]);
    s = 20'(s[15:0]) + 20'(s[19:16]);
    return ~s[15:0];
  endfunction

endpackage

// File: rtl/tg_regs.sv
module tg_regs
  import tg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int GAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [REG_AW-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              busy,
  output logic              rise_raw,
  output logic              rise_udp,
  output logic              sel_raw,
  output logic [CNT_W-1:0]  cnt,
  output logic [GAP_W-1:0]  gap,
  output logic [47:0]       dmac,
  output logic [47:0]       smac,
  output logic [31:0]       sip,
  output logic [31:0]       dip,
  output logic [15:0]       sport,
  output logic [15:0]       dport,
  output logic [FLD_W-1:0]  raw_len,
  output logic [FLD_W-1:0]  udp_len
);

  logic [1:0] ctrl_q;
  logic       wr_en;
  logic       ctrl_wr;

  assign wr_en   = psel & penable & pwrite;
  assign ctrl_wr = wr_en & (paddr == A_CTRL);

  // start bits fire on a 0 -> 1 change of the stored value
  assign rise_raw = ctrl_wr & pwdata[1] & ~ctrl_q[1];
  assign rise_udp = ctrl_wr & pwdata[0] & ~ctrl_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sel_raw <= 1'b0;
      cnt     <= '0;
      gap     <= '0;
      dmac    <= '0;
      smac    <= '0;
      sip     <= '0;
      dip     <= '0;
      sport   <= '0;
      dport   <= '0;
      raw_len <= '0;
      udp_len <= '0;
    end else if (wr_en) begin
      case (paddr)
        A_CTRL:    ctrl_q        <= pwdata[1:0];
        A_SEL:     sel_raw       <= pwdata[0];
        A_BURST: begin
          cnt <= pwdata[CNT_W-1:0];
          gap <= pwdata[16 +: GAP_W];
        end
        A_DMAC_LO: dmac[31:0]    <= pwdata[31:0];
        A_DMAC_HI: dmac[47:32]   <= pwdata[15:0];
        A_SMAC_LO: smac[31:0]    <= pwdata[31:0];
        A_SMAC_HI: smac[47:32]   <= pwdata[15:0];
        A_SIP:     sip           <= pwdata[31:0];
        A_DIP:     dip           <= pwdata[31:0];
        A_PORTS: begin
          sport <= pwdata[15:0];
          dport <= pwdata[31:16];
        end
        A_RAWLEN:  raw_len       <= pwdata[FLD_W-1:0];
        A_UDPLEN:  udp_len       <= pwdata[FLD_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      A_CTRL: begin
        prdata[1:0] = ctrl_q;
        prdata[8]   = busy;
      end
      A_SEL:     prdata[0] = sel_raw;
      A_BURST: begin
        prdata[CNT_W-1:0] = cnt;
        prdata[16 +: GAP_W] = gap;
      end
      A_DMAC_LO: prdata[31:0] = dmac[31:0];
      A_DMAC_HI: prdata[15:0] = dmac[47:32];
      A_SMAC_LO: prdata[31:0] = smac[31:0];
      A_SMAC_HI: prdata[15:0] = smac[47:32];
      A_SIP:     prdata[31:0] = sip;
      A_DIP:     prdata[31:0] = dip;
      A_PORTS:   prdata[31:0] = {dport, sport};
      A_RAWLEN:  prdata[FLD_W-1:0] = raw_len;
      A_UDPLEN:  prdata[FLD_W-1:0] = udp_len;
      default:   prdata = '0;
    endcase
  end

endmodule

// File: rtl/tg_seq.sv
module tg_seq
  import tg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             launch_raw,
  input  logic [FLD_W-1:0] len_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [GAP_W-1:0] gap_in,
  input  logic             tready,
  output logic             busy,
  output logic             sending,
  output logic             mode_raw,
  output logic [IDX_W-1:0] idx,
  output logic [FLD_W-1:0] len_q,
  output logic             last_byte,
  output logic             frame_end,
  output logic             more_frames,
  output logic             gap_zero
);

  seq_st_t          st;
  logic [CNT_W-1:0] left;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] gcnt;
  logic [IDX_W-1:0] last_idx;

  assign last_idx    = hdr_len(mode_raw) + IDX_W'(len_q) - IDX_W'(1);
  assign sending     = (st == ST_SEND);
  assign busy        = (st != ST_IDLE);
  assign last_byte   = sending && (idx == last_idx);
  assign frame_end   = last_byte && tready;
  assign more_frames = (left != CNT_W'(1));
  assign gap_zero    = (gap_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      left     <= '0;
      gap_q    <= '0;
      gcnt     <= '0;
      idx      <= '0;
      len_q    <= '0;
      mode_raw <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (launch) begin
            st       <= ST_SEND;
            idx      <= '0;
            left     <= cnt_in;
            gap_q    <= gap_in;
            len_q    <= len_in;
            mode_raw <= launch_raw;
          end
        end
        ST_SEND: begin
          if (tready) begin
            if (last_byte) begin
              idx <= '0;
              if (!more_frames) begin
                st <= ST_IDLE;
              end else begin
                left <= left - CNT_W'(1);
                if (!gap_zero) begin
                  st   <= ST_GAP;
                  gcnt <= gap_q;
                end
              end
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        ST_GAP: begin
          gcnt <= gcnt - GAP_W'(1);
          if (gcnt == GAP_W'(1)) st <= ST_SEND;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tg_frame.sv
module tg_frame
  import tg_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             mode_raw,
  input  logic [FLD_W-1:0] len,
  input  logic [47:0]      dmac,
  input  logic [47:0]      smac,
  input  logic [31:0]      sip,
  input  logic [31:0]      dip,
  input  logic [15:0]      sport,
  input  logic [15:0]      dport,
  output logic [7:0]       byte_out
);

  logic [15:0] tot_len;
  logic [15:0] udp_len;
  logic [15:0] csum;
  logic [5:0]  k;

  assign tot_len = len + 16'd28;
  assign udp_len = len + 16'd8;
  assign csum    = ip_csum(tot_len, sip, dip);
  assign k       = idx[5:0];

  always_comb begin
    byte_out = 8'h00;
    if (idx >= hdr_len(mode_raw)) begin
      byte_out = idx[7:0] - 8'd42;
    end else if (k < 6'd6) begin
      byte_out = mac_byte(dmac, k[2:0]);
    end else if (k < 6'd12) begin
      byte_out = mac_byte(smac, 3'(k - 6'd6));
    end else if (mode_raw) begin
      byte_out = (k == 6'd12) ? len[15:8] : len[7:0];
    end else begin
      case (k)
        6'd12: byte_out = 8'h08;
        6'd13: byte_out = 8'h00;
        6'd14: byte_out = 8'h45;
        6'd16: byte_out = tot_len[15:8];
        6'd17: byte_out = tot_len[7:0];
        6'd22: byte_out = IP_TTL;
        6'd23: byte_out = IP_PROTO;
        6'd24: byte_out = csum[15:8];
        6'd25: byte_out = csum[7:0];
        6'd26: byte_out = sip[31:24];
        6'd27: byte_out = sip[23:16];
        6'd28: byte_out = sip[15:8];
        6'd29: byte_out = sip[7:0];
        6'd30: byte_out = dip[31:24];
        6'd31: byte_out = dip[23:16];
        6'd32: byte_out = dip[15:8];
        6'd33: byte_out = dip[7:0];
        6'd34: byte_out = sport[15:8];
        6'd35: byte_out = sport[7:0];
        6'd36: byte_out = dport[15:8];
        6'd37: byte_out = dport[7:0];
        6'd38: byte_out = udp_len[15:8];
        6'd39: byte_out = udp_len[7:0];
        default: byte_out = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/eth_test_gen.sv
module eth_test_gen
  import tg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int GAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [REG_AW-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic [7:0]        m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);

  logic             busy, sending, mode_raw;
  logic             rise_raw, rise_udp, sel_raw;
  logic [CNT_W-1:0] cnt;
  logic [GAP_W-1:0] gap;
  logic [47:0]      dmac, smac;
  logic [31:0]      sip, dip;
  logic [15:0]      sport, dport;
  logic [FLD_W-1:0] raw_len, udp_len, len_q;
  logic [IDX_W-1:0] idx;
  logic             last_byte, frame_end, more_frames, gap_zero;
  logic             launch_raw, launch_udp, launch;
  logic [7:0]       frame_byte;

  tg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .busy(busy),
    .rise_raw(rise_raw), .rise_udp(rise_udp), .sel_raw(sel_raw),
    .cnt(cnt), .gap(gap), .dmac(dmac), .smac(smac), .sip(sip), .dip(dip),
    .sport(sport), .dport(dport), .raw_len(raw_len), .udp_len(udp_len)
  );

  // a start counts only when idle, matched to the selected mode, with a nonzero count
  assign launch_raw = rise_raw &  sel_raw & ~busy & (cnt != '0);
  assign launch_udp = rise_udp & ~sel_raw & ~busy & (cnt != '0);
  assign launch     = launch_raw | launch_udp;

  tg_seq #(.CNT_W(CNT_W), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_raw(launch_raw),
    .len_in(launch_raw ? raw_len : udp_len), .cnt_in(cnt), .gap_in(gap),
    .tready(m_tready), .busy(busy), .sending(sending), .mode_raw(mode_raw),
    .idx(idx), .len_q(len_q), .last_byte(last_byte), .frame_end(frame_end),
    .more_frames(more_frames), .gap_zero(gap_zero)
  );

  tg_frame u_frame (
    .idx(idx), .mode_raw(mode_raw), .len(len_q), .dmac(dmac), .smac(smac),
    .sip(sip), .dip(dip), .sport(sport), .dport(dport), .byte_out(frame_byte)
  );

  assign m_tvalid = sending;
  assign m_tlast  = last_byte;
  assign m_tdata  = sending ? frame_byte : 8'h00;

endmodule

// File: rtl/tg_chk.sv
module tg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] m_tdata,
  input logic       m_tvalid,
  input logic       m_tready,
  input logic       m_tlast,
  input logic       busy,
  input logic       launch,
  input logic       frame_end,
  input logic       more_frames,
  input logic       gap_zero
);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_tvalid);

  // R3
  launch_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && m_tvalid);

  // R11
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));

  // R9
  gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && more_frames && !gap_zero |=> !m_tvalid);

  // R9
  gap_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && more_frames && gap_zero |=> m_tvalid);

  // R8
  burst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !more_frames |=> !busy);

endmodule

bind eth_test_gen tg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
  .m_tready(m_tready), .m_tlast(m_tlast), .busy(busy), .launch(launch),
  .frame_end(frame_end), .more_frames(more_frames), .gap_zero(gap_zero)
);

// File: tb/sim_eth_test_gen.sv
`timescale 1ns/1ps
module sim_eth_test_gen;

  typedef struct {
    logic [7:0] b;
    logic       last;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [3:0]  paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata;
  logic [7:0]  m_tdata;
  logic        m_tvalid, m_tlast, m_tready;
  logic        bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  int total = 0, bad = 0;
  exp_t q[$];
  int exp_burst = 0, rx_burst = 0, exp_gap = 0, gap_cnt = 0;
  bit in_gap = 0;
  bit done = 0;

  localparam logic [47:0] DMAC = 48'h0A1B2C3D4E5F;
  localparam logic [47:0] SMAC = 48'h025566778899;
  localparam logic [31:0] SIP  = 32'hC0A80A01;
  localparam logic [31:0] DIP  = 32'hC0A80A02;
  localparam logic [15:0] SPRT = 16'h04D2;
  localparam logic [15:0] DPRT = 16'h1F90;

  always #10 clk = ~clk;

  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign m_tready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;

  eth_test_gen u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .m_tdata(m_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; penable = 1; pwrite = 0; paddr = a;
    #8 d = prdata;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  // scoreboard driver: expected bytes of one frame, built from the byte layout rules
  task automatic push_frame(input bit raw, input int n);
    logic [7:0] h[0:41];
    int hl, s;
    logic [15:0] tl, ul, cs;
    hl = raw ? 14 : 42;
    for (int i = 0; i < 42; i++) h[i] = 8'h00;
    for (int i = 0; i < 6; i++) begin
      h[i]   = DMAC[47 - 8*i -: 8];
      h[6+i] = SMAC[47 - 8*i -: 8];
    end
    if (raw) begin
      h[12] = n[15:8]; h[13] = n[7:0];
    end else begin
      tl = 16'(n + 28); ul = 16'(n + 8);
      h[12] = 8'h08; h[14] = 8'h45;
      h[16] = tl[15:8]; h[17] = tl[7:0];
      h[22] = 8'd64; h[23] = 8'd17;
      for (int i = 0; i < 4; i++) begin
        h[26+i] = SIP[31 - 8*i -: 8];
        h[30+i] = DIP[31 - 8*i -: 8];
      end
      h[34] = SPRT[15:8]; h[35] = SPRT[7:0];
      h[36] = DPRT[15:8]; h[37] = DPRT[7:0];
      h[38] = ul[15:8];   h[39] = ul[7:0];
      s = 0;
      for (int i = 14; i < 34; i += 2) s += {h[i], h[i+1]};
      while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
      cs = ~s[15:0];
      h[24] = cs[15:8]; h[25] = cs[7:0];
    end
    for (int k = 0; k < hl + n; k++) begin
      exp_t e;
      if (k < hl) begin
        e.b = h[k];
        e.tag = (k == 24 || k == 25) ? "R5 checksum" : (raw ? "R6 raw header" : "R4 udp header");
      end else begin
        e.b = 8'(k - 42);
        e.tag = "R7 payload";
      end
      e.last = (k == hl + n - 1);
      if (n == 0 && e.last) e.tag = "R12 empty frame";
      q.push_back(e);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (m_tvalid) begin
        if (in_gap) begin
          check(gap_cnt == exp_gap, "R9 gap length", gap_cnt, exp_gap);
          in_gap = 0;
        end
        if (m_tready) begin
          if (q.size() == 0) begin
            check(0, "R8 unexpected byte", m_tdata, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(m_tdata == e.b, e.tag, m_tdata, e.b);
            check(m_tlast == e.last, "R8 tlast position", m_tlast, e.last);
          end
          if (m_tlast) begin
            rx_burst++;
            if (rx_burst < exp_burst) begin
              in_gap = 1; gap_cnt = 0;
            end
          end
        end
      end else if (in_gap) begin
        gap_cnt++;
      end
    end
  end

  task automatic wait_idle();
    logic [31:0] d;
    int guard = 0;
    do begin
      reg_rd(4'd0, d);
      guard++;
    end while (d[8] && guard < 40000);
    repeat (3) @(posedge clk);
  endtask

  task automatic run_burst(input bit raw, input int n, input int cnt, input int gap, input string tag);
    reg_wr(4'd1, {31'd0, raw});
    reg_wr(4'd2, {16'(gap), 16'(cnt)});
    reg_wr(raw ? 4'd10 : 4'd11, 32'(n));
    for (int f = 0; f < cnt; f++) push_frame(raw, n);
    exp_burst = cnt; rx_burst = 0; exp_gap = gap; in_gap = 0;
    reg_wr(4'd0, raw ? 32'd2 : 32'd1);
    reg_wr(4'd0, 32'd0);
    wait_idle();
    check(q.size() == 0, {tag, " missing bytes"}, q.size(), 0);
    check(rx_burst == cnt, {tag, " frame count"}, rx_burst, cnt);
    q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] vals[12];
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(m_tvalid == 0 && m_tlast == 0, "R1 reset outputs", {m_tvalid, m_tlast}, 0);
    rst_n = 1;
    for (int a = 0; a < 12; a++) begin
      reg_rd(4'(a), d);
      check(d == 0, "R1 reset register", d, 0);
    end

    // R2 readback
    vals = '{32'h0, 32'h1, 32'h0005_0003, 32'hDEADBEEF, 32'h0000_1234, 32'h89ABCDEF,
             32'h0000_5678, 32'h01020304, 32'h05060708, 32'hA5A55A5A, 32'h0000_0100, 32'h0000_0200};
    for (int a = 1; a < 12; a++) reg_wr(4'(a), vals[a]);
    for (int a = 1; a < 12; a++) begin
      reg_rd(4'(a), d);
      check(d == vals[a], "R2 readback", d, vals[a]);
    end
    reg_wr(4'd2, 32'h0);
    reg_wr(4'd3, DMAC[31:0]); reg_wr(4'd4, {16'h0, DMAC[47:32]});
    reg_wr(4'd5, SMAC[31:0]); reg_wr(4'd6, {16'h0, SMAC[47:32]});
    reg_wr(4'd7, SIP); reg_wr(4'd8, DIP);
    reg_wr(4'd9, {DPRT, SPRT});

    // R4 R5 R7 R9 UDP burst with gap
    run_burst(0, 5, 3, 4, "R8 udp burst");
    // R6 R10 raw burst, back-to-back, with backpressure
    bp_en = 1;
    run_burst(1, 20, 2, 0, "R10 raw stalled burst");
    run_burst(0, 60, 2, 1, "R10 udp stalled burst");
    bp_en = 0;
    // R12 header-only frames
    run_burst(0, 0, 1, 0, "R12 udp empty");
    run_burst(1, 0, 2, 2, "R12 raw empty");
    // R7 payload wrap past 256
    run_burst(0, 600, 1, 0, "R7 long payload");

    // R3 mismatched start: SEL = UDP, raw start bit written
    reg_wr(4'd1, 32'd0);
    reg_wr(4'd2, 32'd1);
    reg_wr(4'd0, 32'd2);
    reg_wr(4'd0, 32'd0);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check(m_tvalid == 0, "R3 mismatched start ignored", m_tvalid, 0);
    end
    reg_rd(4'd0, d);
    check(d[8] == 0, "R3 busy after mismatch", d[8], 0);

    // R11 count zero launches nothing
    reg_wr(4'd2, 32'd0);
    reg_wr(4'd0, 32'd1);
    reg_wr(4'd0, 32'd0);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      check(m_tvalid == 0, "R11 zero count", m_tvalid, 0);
    end

    // R11 start while busy ignored; R2 busy bit
    reg_wr(4'd2, 32'd1);
    reg_wr(4'd11, 32'd300);
    push_frame(0, 300);
    exp_burst = 1; rx_burst = 0; in_gap = 0;
    reg_wr(4'd0, 32'd1);
    reg_wr(4'd0, 32'd0);
    reg_rd(4'd0, d);
    check(d[8] == 1, "R2 busy bit during burst", d[8], 1);
    reg_wr(4'd0, 32'd1);
    reg_wr(4'd0, 32'd0);
    wait_idle();
    repeat (400) @(negedge clk);
    check(q.size() == 0, "R11 frame bytes", q.size(), 0);
    check(rx_burst == 1, "R11 restart ignored", rx_burst, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule